// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block moves a block of words between one I/O device and memory without the processor copying each word. Software first writes four things: the memory address where the block begins, how many words to move, a selector naming the device, and a control word. The control word starts the transfer and chooses whether data flows from the device into memory or from memory out to the device. It also chooses the bus policy.

Once started, the controller waits for the device to request service. It then asks the processor for the bus and moves words only after the processor grants it. There are two bus policies. In burst mode the bus is kept for the whole block. In cycle-steal mode the bus is given back after every word and asked for again. When the last word has moved, the controller raises an interrupt. A read of the status register clears that interrupt.

Top module: `dma_ctrl`

## Requirements
- R1: Register offsets on `reg_addr`: 1 holds the memory address, 2 holds the remaining word count and 3 holds the device selector (driven on `dev_sel`). Reads at offsets 1 and 2 return the live values. Writes to any register while the controller is busy have no effect.
- R2: A write to offset 0 with bit 0 set starts a transfer. Bit 1 chooses the policy (0 = burst, 1 = cycle steal). Bit 2 chooses the direction (0 = device to memory, 1 = memory to device). With a nonzero count, the controller becomes busy (status bit 0) but keeps `hold` low until `dev_req` is seen.
- R3: `mem_rd`, `mem_wr` and `dev_ack` are asserted only in a cycle where both `hold` and `hlda` are high. `dev_ack` is asserted only while `dev_req` is high.
- R4: Each word moved (one cycle with `dev_ack` high) lowers the count by one and raises the address by one. `mem_addr` carries the current address.
- R5: In burst mode, with `dev_req` held high, the whole block moves under a single assertion of `hold`, one word per cycle.
- R6: In cycle-steal mode, exactly one word moves per grant. `hold` falls in the cycle after the word, and a new request is made only once `hlda` is low.
- R7: In the cycle after the last word, `hold` is low, the controller is no longer busy, and both `done` (status bit 1) and `irq` (status bit 2, also on the port) are high.
- R8: A read at offset 0 clears `irq` from the next cycle on. `done` stays set until the next start.
- R9: A start with a word count of zero sets `done` and `irq` in the next cycle. `hold` is never raised and busy stays low.
- R10: In burst mode, if `dev_req` is low in a granted cycle, no word moves and the bus is released with the remaining count kept. The transfer resumes with a new request when `dev_req` returns.
- R11: In a word cycle, a device-to-memory transfer pulses `mem_wr` with `mem_wdata` equal to `dev_din`. A memory-to-device transfer pulses `mem_rd` and presents `mem_rdata` on `dev_dout` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at offset 0 clears irq) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| dev_req | input | 1 | Service request from the device |
| dev_ack | output | 1 | Word strobe to the device |
| dev_sel | output | DEV_W | Programmed device selector |
| dev_din | input | DW | Data from the device |
| dev_dout | output | DW | Data to the device |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench sweeps both bus policies and both directions over block lengths of 0, 1, 2, 3 and 6 words. This separates four cases: a start with nothing to move, a block that ends on its first word, a block that repeats the per-word step, and a longer block. Counting how often `hold` rises tells a single burst grant apart from one grant per word. Comparing memory or device contents against arithmetic patterns confirms the data routing and the address stepping. A separate burst run drops `dev_req` partway through the block, tries to write the count while the controller is busy, and then resumes. This shows that the remaining count is kept and that the bus is released and requested again.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2,
        ST_XFER = 2'd3
    } dma_state_e;

    localparam logic [1:0] OFS_CTRL  = 2'd0;
    localparam logic [1:0] OFS_ADDR  = 2'd1;
    localparam logic [1:0] OFS_COUNT = 2'd2;
    localparam logic [1:0] OFS_DEV   = 2'd3;

    localparam int CTL_GO    = 0;
    localparam int CTL_STEAL = 1;
    localparam int CTL_TODEV = 2;

    typedef struct packed {
        logic to_dev;
        logic steal;
    } xfer_cfg_t;

    typedef struct packed {
        logic to_dev;
        logic steal;
        logic irq;
        logic done;
        logic busy;
    } status_t;

    function automatic xfer_cfg_t decode_ctrl(input logic [2:0] bits);
        xfer_cfg_t c;
        c.to_dev = bits[CTL_TODEV];
        c.steal  = bits[CTL_STEAL];
        return c;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int DEV_W     = 8,
    parameter int ADDR_STEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             busy,
    input  logic             fire,
    input  status_t          stat,
    output logic [DW-1:0]    reg_rdata,
    output logic             start_cmd,
    output xfer_cfg_t        cfg,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    cur_count,
    output logic [DEV_W-1:0] dev_sel,
    output logic             count_zero,
    output logic             count_last
);

    localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic wr_ok;
    assign wr_ok     = reg_wr && !busy;
    assign start_cmd = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[CTL_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            cur_addr  <= '0;
            cur_count <= '0;
            dev_sel   <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_CTRL:  if (reg_wdata[CTL_GO]) cfg <= decode_ctrl(reg_wdata[2:0]);
                OFS_ADDR:  cur_addr  <= reg_wdata[AW-1:0];
                OFS_COUNT: cur_count <= reg_wdata[CW-1:0];
                default:   dev_sel   <= reg_wdata[DEV_W-1:0];
            endcase
        end else if (fire) begin
            cur_addr  <= cur_addr + STEP;
            cur_count <= cur_count - ONE;
        end
    end

    assign count_zero = (cur_count == '0);
    assign count_last = (cur_count == ONE);

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = DW'(stat);
            OFS_ADDR:  reg_rdata = DW'(cur_addr);
            OFS_COUNT: reg_rdata = DW'(cur_count);
            default:   reg_rdata = DW'(dev_sel);
        endcase
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_cmd,
    input  logic count_zero,
    input  logic count_last,
    input  logic steal,
    input  logic dev_req,
    input  logic hlda,
    output logic busy,
    output logic hold,
    output logic fire,
    output logic finish
);

    dma_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign fire = (state == ST_XFER) && dev_req && hlda;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start_cmd && !count_zero) state_nx = ST_WAIT;
            ST_WAIT: if (dev_req && !hlda)         state_nx = ST_REQ;
            ST_REQ:  if (hlda)                     state_nx = ST_XFER;
            ST_XFER: begin
                if (fire) begin
                    if (count_last)  state_nx = ST_IDLE;
                    else if (steal)  state_nx = ST_WAIT;
                end else if (!dev_req) begin
                    state_nx = ST_WAIT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy   = (state != ST_IDLE);
    assign hold   = (state == ST_REQ) || (state == ST_XFER);
    assign finish = ((state == ST_IDLE) && start_cmd && count_zero) || (fire && count_last);

endmodule

// File: rtl/dma_flags.sv
module dma_flags (
    input  logic clk,
    input  logic rst,
    input  logic start_cmd,
    input  logic finish,
    input  logic status_rd,
    output logic done,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (finish)         done <= 1'b1;
            else if (start_cmd) done <= 1'b0;

            if (finish)                      irq <= 1'b1;
            else if (start_cmd || status_rd) irq <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int DEV_W     = 8,
    parameter int ADDR_STEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    input  logic             dev_req,
    output logic             dev_ack,
    output logic [DEV_W-1:0] dev_sel,
    input  logic [DW-1:0]    dev_din,
    output logic [DW-1:0]    dev_dout,
    output logic             hold,
    input  logic             hlda,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);

    xfer_cfg_t     cfg;
    status_t       stat;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;
    logic          start_cmd, count_zero, count_last;
    logic          seq_busy, fire, finish, done_flag, cfg_steal;

    assign cfg_steal = cfg.steal;

    dma_regs #(
        .DW(DW), .AW(AW), .CW(CW), .DEV_W(DEV_W), .ADDR_STEP(ADDR_STEP)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(seq_busy), .fire(fire), .stat(stat),
        .reg_rdata(reg_rdata), .start_cmd(start_cmd), .cfg(cfg),
        .cur_addr(cur_addr), .cur_count(cur_count), .dev_sel(dev_sel),
        .count_zero(count_zero), .count_last(count_last)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .count_zero(count_zero),
        .count_last(count_last), .steal(cfg.steal), .dev_req(dev_req),
        .hlda(hlda), .busy(seq_busy), .hold(hold), .fire(fire), .finish(finish)
    );

    dma_flags u_flags (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .finish(finish),
        .status_rd(reg_rd && (reg_addr == OFS_CTRL)),
        .done(done_flag), .irq(irq)
    );

    always_comb begin
        stat.to_dev = cfg.to_dev;
        stat.steal  = cfg.steal;
        stat.irq    = irq;
        stat.done   = done_flag;
        stat.busy   = seq_busy;
    end

    assign dev_ack   = fire;
    assign mem_wr    = fire && !cfg.to_dev;
    assign mem_rd    = fire && cfg.to_dev;
    assign mem_addr  = cur_addr;
    assign mem_wdata = dev_din;
    assign dev_dout  = mem_rdata;

endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          hold,
    input logic          hlda,
    input logic          dev_req,
    input logic          dev_ack,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          irq,
    input logic          busy,
    input logic          steal,
    input logic [CW-1:0] cur_count
);

    assert_strobe_granted_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr || dev_ack) |-> (hold && hlda));

    assert_ack_requested_R3: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> dev_req);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        dev_ack |=> (cur_count == $past(cur_count) - CW'(1)));

    assert_steal_release_R6: assert property (@(posedge clk) disable iff (rst)
        (dev_ack && steal) |=> !hold);

    assert_finish_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (!hold && !busy));

    assert_idle_no_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !hold);

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

endmodule

bind dma_ctrl dma_ctrl_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .hold(hold), .hlda(hlda), .dev_req(dev_req),
    .dev_ack(dev_ack), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq),
    .busy(seq_busy), .steal(cfg_steal), .cur_count(cur_count)
);

// File: tb/dma_ctrl_bench.sv
module dma_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq, dev_req, dev_ack, hold, hlda;
    logic [7:0]  dev_sel;
    logic [15:0] dev_din, dev_dout, mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;

    logic [15:0] mem [0:63];
    logic [15:0] devbuf [0:15];
    logic [15:0] ack_cnt;
    int          hold_rises, strobe_viol;
    logic        hold_q;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctrl u_dma_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dev_req(dev_req), .dev_ack(dev_ack), .dev_sel(dev_sel),
        .dev_din(dev_din), .dev_dout(dev_dout), .hold(hold), .hlda(hlda),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[5:0]];
    assign dev_din   = 16'hA000 + ack_cnt;

    always @(posedge clk) begin
        hlda   <= rst ? 1'b0 : hold;
        hold_q <= hold;
        if (hold && !hold_q) hold_rises <= hold_rises + 1;
        if ((mem_rd || mem_wr || dev_ack) && !(hold && hlda)) strobe_viol <= strobe_viol + 1;
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (dev_ack) begin
            devbuf[ack_cnt[3:0]] <= dev_dout;
            ack_cnt <= ack_cnt + 16'd1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic prep();
        for (int i = 0; i < 64; i++) mem[i] = 16'h5000 + 16'(i);
        for (int i = 0; i < 16; i++) devbuf[i] = 16'h0;
        ack_cnt = 0; hold_rises = 0; strobe_viol = 0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 400 && !irq; k++) @(negedge clk);
    endtask

    task automatic run_xfer(input logic steal, input logic to_dev, input int n, input int start);
        logic [15:0] v;
        int mism;
        int exp_rises;
        prep();
        wr(2'd1, 16'(start));
        wr(2'd2, 16'(n));
        wr(2'd3, 16'h40 + 16'(n));
        wr(2'd0, {13'd0, to_dev, steal, 1'b1});
        dev_req = 1'b1;
        wait_irq();
        dev_req = 1'b0;
        @(negedge clk);
        exp_rises = (n == 0) ? 0 : (steal ? n : 1);
        chk("R7", "irq port at end", 32'(irq), 1);
        chk("R4", "words acknowledged", 32'(ack_cnt), 32'(n));
        chk("R3", "strobes without grant", 32'(strobe_viol), 0);
        if (n == 0)     chk("R9", "hold rises zero count", 32'(hold_rises), 0);
        else if (steal) chk("R6", "hold rises per word", 32'(hold_rises), 32'(exp_rises));
        else            chk("R5", "hold rises burst", 32'(hold_rises), 32'(exp_rises));
        mism = 0;
        for (int i = 0; i < n; i++) begin
            if (to_dev) begin
                if (devbuf[i] !== 16'h5000 + 16'(start + i)) mism++;
            end else begin
                if (mem[start + i] !== 16'hA000 + 16'(i)) mism++;
            end
        end
        chk("R11", "data mismatches", 32'(mism), 0);
        rd(2'd0, v);
        chk("R7", "status busy/done/irq", 32'(v[2:0]), 32'h6);
        rd(2'd0, v);
        chk("R8", "status after clear", 32'(v[2:0]), 32'h2);
        chk("R8", "irq port after clear", 32'(irq), 0);
        rd(2'd1, v);
        chk("R4", "final address", 32'(v), 32'(start + n));
        rd(2'd2, v);
        chk("R4", "final count", 32'(v), 0);
        rd(2'd3, v);
        chk("R1", "device selector", 32'(v), 32'(16'h40 + 16'(n)));
        chk("R1", "dev_sel port", 32'(dev_sel), 32'(8'h40 + 8'(n)));
        chk("R7", "hold low at end", 32'(hold), 0);
    endtask

    initial begin
        logic [15:0] v;
        int mism;
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; dev_req = 0;
        prep();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R7", "reset hold", 32'(hold), 0);
        chk("R7", "reset irq", 32'(irq), 0);
        rd(2'd0, v);
        chk("R2", "reset status", 32'(v), 0);
        rd(2'd2, v);
        chk("R1", "reset count", 32'(v), 0);

        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 5; s++) begin
                    int n;
                    n = (s == 4) ? 6 : s;
                    run_xfer(m[0], d[0], n, 8 + 4 * s);
                end

        // burst with a request gap (R10), busy-time write ignored (R1)
        prep();
        wr(2'd1, 16'd30);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0001);
        @(negedge clk); @(negedge clk);
        chk("R2", "no hold before request", 32'(hold), 0);
        rd(2'd0, v);
        chk("R2", "busy after start", 32'(v[0]), 1);
        dev_req = 1'b1;
        for (int k = 0; k < 100 && ack_cnt != 16'd2; k++) @(negedge clk);
        dev_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10", "bus released on request drop", 32'(hold), 0);
        rd(2'd2, v);
        chk("R10", "count kept", 32'(v), 2);
        wr(2'd2, 16'd9);
        rd(2'd2, v);
        chk("R1", "count write while busy", 32'(v), 2);
        rd(2'd1, v);
        chk("R10", "address kept", 32'(v), 32);
        chk("R10", "no words during gap", 32'(ack_cnt), 2);
        dev_req = 1'b1;
        wait_irq();
        dev_req = 1'b0;
        chk("R10", "words after resume", 32'(ack_cnt), 4);
        chk("R10", "hold rises with gap", 32'(hold_rises), 2);
        mism = 0;
        for (int i = 0; i < 4; i++) if (mem[30 + i] !== 16'hA000 + 16'(i)) mism++;
        chk("R10", "data after resume", 32'(mism), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule